// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches sixteen external interrupt lines and turns qualified signal transitions into pending interrupt requests. Each line picks its source from one of three GPIO ports through a two-bit select field that a separate routing configuration block supplies. The selected signal passes through a two-flop synchronizer and is compared with its previous sampled value to find rising and falling edges.

A memory-mapped register window lets software work with the lines. It holds an interrupt enable mask, an event mask, rising and falling trigger selects, software trigger bits and pending bits. A pending line whose enable bit is set drives one of seven request outputs. Lines 0 to 4 each have an output of their own. Lines 5 to 9 share one output and lines 10 to 15 share another. An interrupt controller then turns these outputs into its pending inputs.

Top module: `exti_edge_ctrl`

## Requirements
- R1: After reset every register reads zero and all request outputs are low.
- R2: The window starts at byte address 0x40010400. Word-aligned offsets are 0x00 enable mask, 0x04 event mask, 0x08 rising select, 0x0C falling select, 0x10 software trigger and 0x14 pending. Reads return the stored value. Offsets 0x18 and 0x1C read zero, and writes at unaligned addresses or outside the 32-byte window change nothing.
- R3: When the selected input rises on an enabled line with its rising select set, the pending bit is set on the third rising clock edge after the input changes, and not before.
- R4: A falling edge sets pending when the falling select is set. With both selects set, either edge sets it. With neither set, input edges never set it.
- R5: An edge on a line whose enable mask bit is clear does not set its pending bit.
- R6: Line l takes its input from port_sel bits [2l+1:2l]: 0 selects port A (gpio_in bit l), 1 selects port B (bit 16+l), 2 selects port C (bit 32+l), and 3 gives a constant low. Edges on ports that are not selected have no effect.
- R7: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. A trigger in the same cycle wins over the clear.
- R8: Writing a 1 to a software trigger bit that reads 0 sets that bit. In the same clock edge it sets the pending bit if the line is enabled. The trigger bit stays 1 until its pending bit is cleared by a write, and writing 1 again while it is set triggers nothing.
- R9: irq_req[0..4] follow lines 0..4 (interrupt numbers 6..10), irq_req[5] covers lines 5..9 (number 23) and irq_req[6] covers lines 10..15 (number 40). An output is high while any member line has both its pending bit and its enable bit set. Clearing the enable bit drops the output but keeps the pending bit.
- R10: The event mask is storage only. It never sets a pending bit or a request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 48 | Port A in bits 15:0, port B in 31:16, port C in 47:32 |
| port_sel | input | 32 | Two-bit source code per line, line l at bits [2l+1:2l] |
| bus_addr | input | 32 | Byte address for register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data, one bit per line |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq_req | output | 7 | Grouped request outputs |

## Verification
The bench builds the block with its default parameters: sixteen lines, three ports, a two-stage synchronizer and group boundaries at lines 5 and 10. With these values all three kinds of output are reachable, along with the unused select code 3 and the unmapped words at the top of the window. Directed cases check the three-edge latency, both trigger selects, masking and the software trigger corners. Several thousand random cycles then mix port reselection, input toggles and register writes. After every clock the bench compares the request outputs and the pending bits with a model of its own.

// File: rtl/exti_pkg.sv
package exti_pkg;

  // Word index inside the register window (byte offset / 4)
  typedef enum logic [2:0] {
    REG_ENABLE  = 3'd0,
    REG_EVENT   = 3'd1,
    REG_RISE    = 3'd2,
    REG_FALL    = 3'd3,
    REG_SWTRIG  = 3'd4,
    REG_PENDING = 3'd5
  } reg_word_e;

  // Request output that a line drives: singles first, then two shared groups
  function automatic int unsigned line_output(input int unsigned line,
                                              input int unsigned n_single,
                                              input int unsigned upper_start);
    if (line < n_single)         return line;
    else if (line < upper_start) return n_single;
    else                         return n_single + 1;
  endfunction

  // Interrupt number carried by a request output
  function automatic int unsigned output_irq_number(input int unsigned out_idx,
                                                    input int unsigned n_single);
    if (out_idx < n_single)       return 6 + out_idx;
    else if (out_idx == n_single) return 23;
    else                          return 40;
  endfunction

endpackage

// File: rtl/exti_port_mux.sv
module exti_port_mux #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned SEL_W     = 2
) (
  input  logic [NUM_PORTS*NUM_LINES-1:0] gpio_in,
  input  logic [NUM_LINES*SEL_W-1:0]     port_sel,
  output logic [NUM_LINES-1:0]           line_raw
);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [SEL_W-1:0] code;
    logic             pick;
    assign code = port_sel[l*SEL_W +: SEL_W];
    always_comb begin
      pick = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (code == SEL_W'(p)) pick = gpio_in[p*NUM_LINES + l];
      end
    end
    assign line_raw[l] = pick;
  end

endmodule

// File: rtl/exti_sync_edge.sv
module exti_sync_edge #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] rise_evt,
  output logic [WIDTH-1:0] fall_evt
);

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] last_q;
  logic [WIDTH-1:0] settled;

  assign settled = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      last_q <= '0;
    end else begin
      chain_q[0] <= raw_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      last_q <= settled;
    end
  end

  assign rise_evt = settled & ~last_q;
  assign fall_evt = ~settled & last_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_chk
    // a single input step gives exactly one detection cycle
    assert_rise_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt[b] |=> !rise_evt[b]);
    assert_fall_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt[b] |=> !fall_evt[b]);
  end

endmodule

// File: rtl/exti_regs.sv
module exti_regs
  import exti_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter logic [31:0] BASE_ADDR = 32'h4001_0400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          bus_addr,
  input  logic                 bus_we,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] rise_evt,
  input  logic [NUM_LINES-1:0] fall_evt,
  output logic [NUM_LINES-1:0] enable_q,
  output logic [NUM_LINES-1:0] pend_q
);

  localparam int unsigned WIN_LSB = 5;

  logic [NUM_LINES-1:0] event_q, rise_q, fall_q, swt_q;
  logic                 hit;
  reg_word_e            word;
  logic                 wr_en, wr_ev, wr_rise, wr_fall, wr_swt, wr_pend;
  logic [NUM_LINES-1:0] hw_trig, sw_trig, pend_set, pend_clr;

  assign hit  = (bus_addr[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB]) && (bus_addr[1:0] == 2'b00);
  assign word = reg_word_e'(bus_addr[WIN_LSB-1:2]);

  assign wr_en   = bus_we && hit && (word == REG_ENABLE);
  assign wr_ev   = bus_we && hit && (word == REG_EVENT);
  assign wr_rise = bus_we && hit && (word == REG_RISE);
  assign wr_fall = bus_we && hit && (word == REG_FALL);
  assign wr_swt  = bus_we && hit && (word == REG_SWTRIG);
  assign wr_pend = bus_we && hit && (word == REG_PENDING);

  // qualified trigger sources, brought out as named wires
  assign hw_trig  = (rise_evt & rise_q) | (fall_evt & fall_q);
  assign sw_trig  = wr_swt ? (bus_wdata & ~swt_q) : '0;
  assign pend_set = (hw_trig | sw_trig) & enable_q;
  assign pend_clr = wr_pend ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      event_q  <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      swt_q    <= '0;
      pend_q   <= '0;
    end else begin
      if (wr_en)   enable_q <= bus_wdata;
      if (wr_ev)   event_q  <= bus_wdata;
      if (wr_rise) rise_q   <= bus_wdata;
      if (wr_fall) fall_q   <= bus_wdata;
      swt_q  <= (wr_swt ? (swt_q | bus_wdata) : swt_q) & ~pend_clr;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (word)
        REG_ENABLE:  bus_rdata = enable_q;
        REG_EVENT:   bus_rdata = event_q;
        REG_RISE:    bus_rdata = rise_q;
        REG_FALL:    bus_rdata = fall_q;
        REG_SWTRIG:  bus_rdata = swt_q;
        REG_PENDING: bus_rdata = pend_q;
        default:     bus_rdata = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    assert_pend_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(enable_q[i]));
    assert_pend_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(rise_evt[i] && rise_q[i] || fall_evt[i] && fall_q[i] || sw_trig[i]));
    assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr[i] && !pend_set[i]) |=> !pend_q[i]);
    assert_pend_zero_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && !bus_wdata[i] && pend_q[i]) |=> pend_q[i]);
    assert_swt_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(swt_q[i]) |-> $past(pend_clr[i]));
  end

endmodule

// File: rtl/exti_irq_group.sv
module exti_irq_group
  import exti_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned N_SINGLE    = 5,
  parameter int unsigned UPPER_START = 10,
  parameter int unsigned NUM_OUT     = N_SINGLE + 2
) (
  input  logic [NUM_LINES-1:0] pend_q,
  input  logic [NUM_LINES-1:0] enable_q,
  output logic [NUM_OUT-1:0]   irq_req
);

  logic [NUM_LINES-1:0] active;
  assign active = pend_q & enable_q;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic any;
    always_comb begin
      any = 1'b0;
      for (int l = 0; l < NUM_LINES; l++) begin
        if (line_output(l, N_SINGLE, UPPER_START) == o) any = any | active[l];
      end
    end
    assign irq_req[o] = any;
  end

endmodule

// File: rtl/exti_edge_ctrl.sv
module exti_edge_ctrl
  import exti_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_SINGLE    = 5,
  parameter int unsigned UPPER_START = 10,
  parameter logic [31:0] BASE_ADDR   = 32'h4001_0400,
  localparam int unsigned NUM_OUT    = N_SINGLE + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*NUM_LINES-1:0] gpio_in,
  input  logic [NUM_LINES*SEL_W-1:0]     port_sel,
  input  logic [31:0]                    bus_addr,
  input  logic                           bus_we,
  input  logic [NUM_LINES-1:0]           bus_wdata,
  output logic [NUM_LINES-1:0]           bus_rdata,
  output logic [NUM_OUT-1:0]             irq_req
);

  logic [NUM_LINES-1:0] line_raw, rise_evt, fall_evt, enable_q, pend_q;

  exti_port_mux #(.NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_mux (
    .gpio_in  (gpio_in),
    .port_sel (port_sel),
    .line_raw (line_raw)
  );

  exti_sync_edge #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (line_raw),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  exti_regs #(.NUM_LINES(NUM_LINES), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .enable_q  (enable_q),
    .pend_q    (pend_q)
  );

  exti_irq_group #(.NUM_LINES(NUM_LINES), .N_SINGLE(N_SINGLE),
                   .UPPER_START(UPPER_START), .NUM_OUT(NUM_OUT)) u_grp (
    .pend_q   (pend_q),
    .enable_q (enable_q),
    .irq_req  (irq_req)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    localparam int unsigned OUT_IDX = line_output(l, N_SINGLE, UPPER_START);
    assert_irq_follows_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[l] && enable_q[l]) |-> irq_req[OUT_IDX]);
  end

endmodule

// File: tb/sim_exti_edge_ctrl.sv
`timescale 1ns/10ps
module sim_exti_edge_ctrl;
  localparam int NL = 16;
  localparam int NOUT = 7;
  localparam logic [31:0] BASE = 32'h4001_0400;
  localparam logic [31:0] O_EN = 0, O_EV = 4, O_RI = 8, O_FA = 12, O_SW = 16, O_PR = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NL-1:0] ga = '0, gb = '0, gc = '0;
  logic [2*NL-1:0] psel = '0;
  logic [31:0] bus_addr = BASE + O_PR;
  logic bus_we = 1'b0;
  logic [NL-1:0] bus_wdata = '0;
  logic [NL-1:0] bus_rdata;
  logic [NOUT-1:0] irq_req;

  exti_edge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .gpio_in({gc, gb, ga}), .port_sel(psel),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // bench model
  logic [NL-1:0] m_en = '0, m_ev = '0, m_ri = '0, m_fa = '0, m_sw = '0, m_pr = '0;
  logic [NL-1:0] h_a = '0, h_b = '0, h_c = '0;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] routed();
    logic [NL-1:0] v;
    for (int l = 0; l < NL; l++) begin
      case (psel[2*l +: 2])
        2'd0: v[l] = ga[l];
        2'd1: v[l] = gb[l];
        2'd2: v[l] = gc[l];
        default: v[l] = 1'b0;
      endcase
    end
    return v;
  endfunction

  function automatic logic [NOUT-1:0] exp_irq();
    logic [NL-1:0] a;
    a = m_pr & m_en;
    return {|a[15:10], |a[9:5], a[4:0]};
  endfunction

  task automatic model_clock(input logic we, input logic [31:0] addr, input logic [NL-1:0] wd);
    logic [NL-1:0] hw, sw, clr, st;
    logic [31:0] ofs;
    logic ok;
    ofs = addr - BASE;
    ok = we && (addr >= BASE) && (ofs < 32) && (ofs[1:0] == 2'b00);
    hw = ((h_b & ~h_c) & m_ri) | ((~h_b & h_c) & m_fa);
    sw = (ok && ofs == O_SW) ? (wd & ~m_sw) : '0;
    clr = (ok && ofs == O_PR) ? wd : '0;
    st = (hw | sw) & m_en;
    if (ok && ofs == O_EN) m_en = wd;
    if (ok && ofs == O_EV) m_ev = wd;
    if (ok && ofs == O_RI) m_ri = wd;
    if (ok && ofs == O_FA) m_fa = wd;
    if (ok && ofs == O_SW) m_sw = m_sw | wd;
    m_sw = m_sw & ~clr;
    m_pr = (m_pr & ~clr) | st;
    h_c = h_b; h_b = h_a; h_a = routed();
  endtask

  // called at negedge+0.5; returns at next negedge+0.5
  task automatic step(input logic we, input logic [31:0] addr, input logic [NL-1:0] wd);
    bus_we = we; bus_addr = addr; bus_wdata = wd;
    @(posedge clk);
    model_clock(we, addr, wd);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = BASE + O_PR; bus_wdata = '0;
    #0.5;
    chk({tag, " irq_req"}, 32'(irq_req), 32'(exp_irq()));
    chk({tag, " pending"}, 32'(bus_rdata), 32'(m_pr));
  endtask

  task automatic wr(input logic [31:0] ofs, input logic [NL-1:0] d);
    step(1'b1, BASE + ofs, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, BASE + O_PR, '0);
  endtask

  task automatic rd(input logic [31:0] addr, input logic [NL-1:0] exp, input string t);
    bus_addr = addr;
    #0.2;
    chk(t, 32'(bus_rdata), 32'(exp));
    bus_addr = BASE + O_PR;
  endtask

  task automatic clear_all();
    wr(O_EN, '0); wr(O_RI, '0); wr(O_FA, '0); wr(O_EV, '0);
    wr(O_PR, '1); ga = '0; gb = '0; gc = '0; psel = '0; idle(4);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    #0.5;
    tag = "R1";
    chk("R1 irq_req after reset", 32'(irq_req), 32'h0);
    rd(BASE + O_EN, '0, "R1 enable reset");
    rd(BASE + O_RI, '0, "R1 rise reset");
    rd(BASE + O_FA, '0, "R1 fall reset");
    rd(BASE + O_SW, '0, "R1 swtrig reset");
    rd(BASE + O_PR, '0, "R1 pending reset");
    @(negedge clk); rst_n = 1'b1; #0.5;

    // R2 register window
    tag = "R2";
    wr(O_EN, 16'hA5A5); wr(O_EV, 16'h1234); wr(O_RI, 16'h0F0F); wr(O_FA, 16'hFF00);
    rd(BASE + O_EN, 16'hA5A5, "R2 enable readback");
    rd(BASE + O_EV, 16'h1234, "R2 event readback");
    rd(BASE + O_RI, 16'h0F0F, "R2 rise readback");
    idle(1);
    rd(BASE + O_FA, 16'hFF00, "R2 fall readback");
    rd(BASE + 32'h18, '0, "R2 unmapped word reads zero");
    step(1'b1, BASE + 32'h20, 16'hFFFF);
    step(1'b1, BASE + 32'h1, 16'hFFFF);
    rd(BASE + O_EN, 16'hA5A5, "R2 outside/unaligned write ignored");
    clear_all();

    // R3 rising edge latency
    tag = "R3";
    wr(O_EN, 16'h0001); wr(O_RI, 16'h0001);
    ga[0] = 1'b1;
    idle(2);
    rd(BASE + O_PR, 16'h0000, "R3 not pending before third edge");
    idle(1);
    rd(BASE + O_PR, 16'h0001, "R3 pending on third edge");
    chk("R3 irq0 high", 32'(irq_req[0]), 32'h1);

    // R7 write-one-to-clear
    tag = "R7";
    wr(O_PR, 16'h0000);
    rd(BASE + O_PR, 16'h0001, "R7 zero write keeps pending");
    wr(O_PR, 16'h0001);
    rd(BASE + O_PR, 16'h0000, "R7 one write clears pending");

    // R4 falling, both, neither
    tag = "R4";
    wr(O_RI, 16'h0002); wr(O_FA, 16'h0003); wr(O_EN, 16'h0007);
    ga[0] = 1'b0; idle(3);
    rd(BASE + O_PR, 16'h0001, "R4 falling edge pends");
    wr(O_PR, 16'hFFFF);
    ga[1] = 1'b1; idle(3);
    rd(BASE + O_PR, 16'h0002, "R4 both selected rising");
    wr(O_PR, 16'hFFFF);
    ga[1] = 1'b0; idle(3);
    rd(BASE + O_PR, 16'h0002, "R4 both selected falling");
    wr(O_PR, 16'hFFFF);
    ga[2] = 1'b1; idle(3); ga[2] = 1'b0; idle(3);
    rd(BASE + O_PR, 16'h0000, "R4 neither selected stays clear");
    clear_all();

    // R5 masked line
    tag = "R5";
    wr(O_RI, 16'h0008); wr(O_FA, 16'h0008);
    ga[3] = 1'b1; idle(3); ga[3] = 1'b0; idle(3);
    rd(BASE + O_PR, 16'h0000, "R5 disabled line ignores edges");
    chk("R5 irq3 low", 32'(irq_req[3]), 32'h0);
    clear_all();

    // R6 port routing
    tag = "R6";
    wr(O_EN, 16'h0010); wr(O_RI, 16'h0010);
    psel[9:8] = 2'd1; idle(3);
    ga[4] = 1'b1; idle(4);
    rd(BASE + O_PR, 16'h0000, "R6 unselected port A ignored");
    gb[4] = 1'b1; idle(3);
    rd(BASE + O_PR, 16'h0010, "R6 port B edge pends");
    wr(O_PR, 16'hFFFF);
    psel[9:8] = 2'd2; gc[4] = 1'b0; idle(3);
    gc[4] = 1'b1; idle(3);
    rd(BASE + O_PR, 16'h0010, "R6 port C edge pends");
    wr(O_PR, 16'hFFFF);
    gc[4] = 1'b0; idle(3);
    psel[9:8] = 2'd3; idle(3);
    ga[4] = 1'b0; gb[4] = 1'b0; gc[4] = 1'b1; idle(3); gb[4] = 1'b1; idle(3);
    rd(BASE + O_PR, 16'h0000, "R6 code 3 gives constant low");
    clear_all();

    // R8 software trigger
    tag = "R8";
    wr(O_EN, 16'h0040);
    wr(O_SW, 16'h0040);
    rd(BASE + O_PR, 16'h0040, "R8 software trigger pends same edge");
    rd(BASE + O_SW, 16'h0040, "R8 trigger bit holds");
    wr(O_PR, 16'h0040);
    rd(BASE + O_SW, 16'h0000, "R8 trigger bit drops with pending clear");
    wr(O_SW, 16'h0080);
    rd(BASE + O_PR, 16'h0000, "R8 disabled line not pended");
    wr(O_EN, 16'h00C0); wr(O_SW, 16'h0080);
    rd(BASE + O_PR, 16'h0000, "R8 rewrite of set bit does not retrigger");
    clear_all();

    // R9 grouping
    tag = "R9";
    wr(O_EN, 16'hFFFF);
    wr(O_SW, 16'h0200);
    chk("R9 line 9 drives shared output 5", 32'(irq_req), 32'h20);
    wr(O_SW, 16'h8000);
    chk("R9 line 15 drives shared output 6", 32'(irq_req), 32'h60);
    wr(O_SW, 16'h0004);
    chk("R9 line 2 drives output 2", 32'(irq_req), 32'h64);
    wr(O_EN, 16'h0000);
    chk("R9 disable drops outputs", 32'(irq_req), 32'h0);
    rd(BASE + O_PR, 16'h8204, "R9 pending kept after disable");
    clear_all();

    // R10 event mask inert
    tag = "R10";
    wr(O_EV, 16'hFFFF);
    ga = 16'hFFFF; idle(3); ga = '0; idle(3);
    rd(BASE + O_PR, 16'h0000, "R10 event mask alone never pends");
    chk("R10 outputs low", 32'(irq_req), 32'h0);
    clear_all();

    // random mix, all requirements checked by the model each cycle
    tag = "R3/R4/R7/R8/R9 random";
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ofs;
      if ($urandom_range(0, 3) == 0) begin
        int p = $urandom_range(0, 2);
        int b = $urandom_range(0, NL - 1);
        if (p == 0) ga[b] = ~ga[b]; else if (p == 1) gb[b] = ~gb[b]; else gc[b] = ~gc[b];
      end
      if ($urandom_range(0, 39) == 0) psel = 32'($urandom());
      if ($urandom_range(0, 4) == 0) begin
        ofs = 32'($urandom_range(0, 7)) * 4;
        step(1'b1, BASE + ofs, NL'($urandom()));
      end else begin
        idle(1);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule